// File: doc/BRIEF.md
# Four-Channel DMA Programming and Arbitration Unit

This unit is the control side of a four-channel memory-to-memory DMA controller. Software programs each channel through a small register bus. Each channel has a source address, a destination address, a count and a control halfword. When a channel's enable bit goes from 0 to 1, the unit copies the programmed addresses into working registers. After a short start-up delay it loads the working count. It then offers the channel to an external transfer engine, one unit at a time, through a start/done handshake.

A fixed-priority picker chooses the owner again before every unit, so a lower-numbered channel can take over between units of a higher-numbered one. When a channel's last unit completes, the unit does four things. It can clear the channel's enable bit. It can restore the working destination. It can pulse a per-channel interrupt. It also drops a CPU bus-hold output once no channel remains active. A parameter selects between two core variants, which differ in the count field width, the zero-count maximum and the control write mask.

Top module: `dma_ctrl_top`

## Requirements
- R1: Writes to a source (reg_sel=0) or destination (reg_sel=1) register store only bits 27..1. Read-back of bit 0 and of bits 31..28 is zero.
- R2: With WIDE=1, a control write (reg_sel=2) works as follows. It takes the count from bits 20..0, and a zero count stores 0x200000. It stores the control halfword as bits 31..16 ANDed with 0xFFE0.
- R3: With WIDE=0, a control write works as follows. It takes the count from bits 15..0. A zero count stores 0x10000 on channel 3 and 0x4000 on channels 0 to 2. It stores the control halfword ANDed with 0xF7E0.
- R4: After reset, each programmed count holds its zero-count maximum. All control halfwords read zero. xfer_start, irq and cpu_hold are low.
- R5: A control write that raises enable (control bit 15) on a disabled channel copies the programmed source and destination into the working addresses. An enabling write to a channel that is already enabled starts nothing.
- R6: With timing code 0 (control bits 13..11), the working count is loaded from the programmed count. The first xfer_start appears after the third rising clock edge following the enabling write edge. Other timing codes never start a transfer.
- R7: Each unit reports the working source, destination and width on xfer_src, xfer_dst and xfer_word. Control bit 10 selects 4-byte units (1) or 2-byte units (0). Each done advances the address by the unit size, according to its 2-bit code. The source code is in bits 8..7 and the destination code in bits 6..5. Code 0 and code 3 increment, code 1 decrements and code 2 holds.
- R8: Before each unit, the lowest-numbered channel that is enabled and has a nonzero working count is granted. A channel enabled later can therefore take over between units.
- R9: When the last unit of a channel completes, its enable bit clears if repeat (bit 9) is off or the timing code is 0. The cleared bit is visible on read-back.
- R10: When the last unit completes with destination code 3, the working destination is restored to the programmed destination.
- R11: When the last unit completes with IRQ enable (bit 14) set, that channel's irq bit is high for exactly one cycle.
- R12: cpu_hold is high while any channel is active or a unit is in flight, and low otherwise. While ext_hold is high, no xfer_start is issued.
- R13: reg_rdata returns, one cycle after the select, the value chosen by reg_rd_sel: 0 source, 1 destination, 2 control halfword in bits 31..16, 3 programmed count, 4 working source, 5 working destination, 6 working count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel addressed by the write |
| reg_sel | input | 2 | Write target: 0 source, 1 destination, 2 control/count |
| reg_wdata | input | 32 | Write data |
| reg_rd_ch | input | 2 | Channel addressed by the read |
| reg_rd_sel | input | 3 | Read target (see R13) |
| reg_rdata | output | 32 | Registered read data |
| ext_hold | input | 1 | CPU held by another agent; defers unit starts |
| xfer_start | output | 1 | One-cycle pulse offering a unit to the engine |
| xfer_ch | output | 2 | Channel of the offered unit |
| xfer_src | output | 32 | Source address of the unit |
| xfer_dst | output | 32 | Destination address of the unit |
| xfer_word | output | 1 | 1 = 4-byte unit, 0 = 2-byte unit |
| xfer_done | input | 1 | Engine reports the unit finished |
| cpu_hold | output | 1 | Holds the CPU off the bus |
| irq | output | 4 | Per-channel completion interrupt pulses |

## Verification
A corrupted working count appears at the ports as a wrong number of xfer_start pulses. It can also show as an irq pulse on the wrong unit, visible as soon as the channel's last unit completes. A stale or wrongly stepped working address shows in the xfer_src or xfer_dst value of the very next unit, or in the read-back of the working registers one cycle after selection. Wrong priority or wrong enable tracking is visible in the channel sequence on xfer_ch. It also shows in a control read-back whose enable bit has not cleared after completion, or in cpu_hold staying high.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CNT_W  = 22;
  localparam int B_DCTL = 5;
  localparam int B_SCTL = 7;
  localparam int B_RPT  = 9;
  localparam int B_WORD = 10;
  localparam int B_TIM  = 11;
  localparam int B_IRQ  = 14;
  localparam int B_EN   = 15;
  localparam logic [31:0] ADDR_MASK = 32'h0FFF_FFFE;

  typedef enum logic [1:0] {
    ADJ_INC = 2'd0,
    ADJ_DEC = 2'd1,
    ADJ_FIX = 2'd2,
    ADJ_RLD = 2'd3
  } adj_e;

  function automatic logic [31:0] next_addr(logic [31:0] a, logic [1:0] code, logic word);
    logic [31:0] step;
    step = word ? 32'd4 : 32'd2;
    case (adj_e'(code))
      ADJ_DEC: return a - step;
      ADJ_FIX: return a;
      default: return a + step;
    endcase
  endfunction
endpackage

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int CH   = 0,
  parameter bit WIDE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_src,
  input  logic             wr_dst,
  input  logic             wr_cnt,
  input  logic [31:0]      wdata,
  input  logic             unit_done,
  output logic [15:0]      ctrl,
  output logic [31:0]      prog_src,
  output logic [31:0]      prog_dst,
  output logic [31:0]      work_src,
  output logic [31:0]      work_dst,
  output logic [CNT_W-1:0] prog_cnt,
  output logic [CNT_W-1:0] work_cnt,
  output logic             active,
  output logic             irq
);
  localparam int CF_W = WIDE ? 21 : 16;
  localparam logic [15:0] CMASK = WIDE ? 16'hFFE0 : 16'hF7E0;
  localparam logic [CNT_W-1:0] CMAX = WIDE ? CNT_W'(32'h200000) :
                                      (CH == 3 ? CNT_W'(32'h10000) : CNT_W'(32'h4000));

  logic [1:0]      dly;
  logic [15:0]     ctrl_new;
  logic [CF_W-1:0] cfield;
  logic            rise, last;

  assign ctrl_new = wdata[31:16] & CMASK;
  assign cfield   = wdata[CF_W-1:0];
  assign rise     = wr_cnt && ctrl_new[B_EN] && !ctrl[B_EN];
  assign last     = unit_done && (work_cnt == CNT_W'(1));
  assign active   = ctrl[B_EN] && (work_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      prog_src <= '0;
      prog_dst <= '0;
      work_src <= '0;
      work_dst <= '0;
      prog_cnt <= CMAX;
      work_cnt <= '0;
      dly      <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= last && ctrl[B_IRQ];
      if (wr_src) prog_src <= wdata & ADDR_MASK;
      if (wr_dst) prog_dst <= wdata & ADDR_MASK;
      if (dly != 2'd0) dly <= dly - 2'd1;
      if (dly == 2'd1) work_cnt <= prog_cnt;
      if (unit_done && work_cnt != '0) begin
        work_cnt <= work_cnt - CNT_W'(1);
        work_src <= next_addr(work_src, ctrl[B_SCTL +: 2], ctrl[B_WORD]);
        work_dst <= next_addr(work_dst, ctrl[B_DCTL +: 2], ctrl[B_WORD]);
      end
      if (last) begin
        if (!ctrl[B_RPT] || ctrl[B_TIM +: 3] == 3'd0) ctrl[B_EN] <= 1'b0;
        if (adj_e'(ctrl[B_DCTL +: 2]) == ADJ_RLD) work_dst <= prog_dst;
      end
      if (wr_cnt) begin
        ctrl     <= ctrl_new;
        prog_cnt <= (cfield == '0) ? CMAX : CNT_W'(cfield);
        if (rise) begin
          work_src <= prog_src;
          work_dst <= prog_dst;
          work_cnt <= '0;
          dly      <= (ctrl_new[B_TIM +: 3] == 3'd0) ? 2'd2 : 2'd0;
        end
      end
    end
  end
endmodule

// File: rtl/dma_ctrl_top.sv
module dma_ctrl_top
  import dma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter bit WIDE = 1'b1,
  localparam int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [CW-1:0] reg_ch,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic [CW-1:0] reg_rd_ch,
  input  logic [2:0]    reg_rd_sel,
  output logic [31:0]   reg_rdata,
  input  logic          ext_hold,
  output logic          xfer_start,
  output logic [CW-1:0] xfer_ch,
  output logic [31:0]   xfer_src,
  output logic [31:0]   xfer_dst,
  output logic          xfer_word,
  input  logic          xfer_done,
  output logic          cpu_hold,
  output logic [NCH-1:0] irq
);
  logic [15:0]      ctrl_a  [NCH];
  logic [31:0]      psrc_a  [NCH];
  logic [31:0]      pdst_a  [NCH];
  logic [31:0]      wsrc_a  [NCH];
  logic [31:0]      wdst_a  [NCH];
  logic [CNT_W-1:0] pcnt_a  [NCH];
  logic [CNT_W-1:0] wcnt_a  [NCH];
  logic [NCH-1:0]   act;
  logic             busy;
  logic             pick_any;
  logic [CW-1:0]    pick_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan #(.CH(g), .WIDE(WIDE)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_src   (reg_wr && reg_ch == CW'(g) && reg_sel == 2'd0),
      .wr_dst   (reg_wr && reg_ch == CW'(g) && reg_sel == 2'd1),
      .wr_cnt   (reg_wr && reg_ch == CW'(g) && reg_sel == 2'd2),
      .wdata    (reg_wdata),
      .unit_done(xfer_done && busy && xfer_ch == CW'(g)),
      .ctrl     (ctrl_a[g]),
      .prog_src (psrc_a[g]),
      .prog_dst (pdst_a[g]),
      .work_src (wsrc_a[g]),
      .work_dst (wdst_a[g]),
      .prog_cnt (pcnt_a[g]),
      .work_cnt (wcnt_a[g]),
      .active   (act[g]),
      .irq      (irq[g])
    );
  end

  dma_pick #(.N(NCH)) u_pick (
    .req(act),
    .any(pick_any),
    .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      xfer_start <= 1'b0;
      xfer_ch    <= '0;
      xfer_src   <= '0;
      xfer_dst   <= '0;
      xfer_word  <= 1'b0;
      cpu_hold   <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      cpu_hold   <= pick_any || busy;
      if (busy) begin
        if (xfer_done) busy <= 1'b0;
      end else if (pick_any && !ext_hold) begin
        busy       <= 1'b1;
        xfer_start <= 1'b1;
        xfer_ch    <= pick_idx;
        xfer_src   <= wsrc_a[pick_idx];
        xfer_dst   <= wdst_a[pick_idx];
        xfer_word  <= ctrl_a[pick_idx][B_WORD];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_rd_sel)
        3'd0:    reg_rdata <= psrc_a[reg_rd_ch];
        3'd1:    reg_rdata <= pdst_a[reg_rd_ch];
        3'd2:    reg_rdata <= {ctrl_a[reg_rd_ch], 16'h0000};
        3'd3:    reg_rdata <= 32'(pcnt_a[reg_rd_ch]);
        3'd4:    reg_rdata <= wsrc_a[reg_rd_ch];
        3'd5:    reg_rdata <= wdst_a[reg_rd_ch];
        3'd6:    reg_rdata <= 32'(wcnt_a[reg_rd_ch]);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_ctrl_sva.sv
module dma_ctrl_sva #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           xfer_start,
  input logic           ext_hold,
  input logic           cpu_hold,
  input logic [NCH-1:0] irq,
  input logic [2:0]     reg_rd_sel,
  input logic [31:0]    reg_rdata
);
  p_start_under_hold_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> cpu_hold);

  p_start_deferred_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> !$past(ext_hold));

  p_start_single_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  p_irq_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq));

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |=> (irq == '0));

  p_addr_clean_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_rd_sel) <= 3'd1) |-> (reg_rdata[0] == 1'b0 && reg_rdata[31:28] == 4'h0));
endmodule

bind dma_ctrl_top dma_ctrl_sva #(.NCH(NCH)) u_sva (.*);

// File: tb/test_dma_ctrl_top.sv
module test_dma_ctrl_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_ch = '0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_rd_ch = '0;
  logic [2:0]  reg_rd_sel = '0;
  logic        ext_hold = 1'b0;
  logic        xfer_done = 1'b0;
  logic [31:0] reg_rdata, reg_rdata_n;
  logic        xfer_start, xfer_start_n;
  logic [1:0]  xfer_ch, xfer_ch_n;
  logic [31:0] xfer_src, xfer_src_n, xfer_dst, xfer_dst_n;
  logic        xfer_word, xfer_word_n;
  logic        cpu_hold, cpu_hold_n;
  logic [3:0]  irq, irq_n;

  dma_ctrl_top #(.NCH(4), .WIDE(1'b1)) i_dma_ctrl_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rd_ch(reg_rd_ch), .reg_rd_sel(reg_rd_sel),
    .reg_rdata(reg_rdata), .ext_hold(ext_hold), .xfer_start(xfer_start),
    .xfer_ch(xfer_ch), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_word(xfer_word), .xfer_done(xfer_done), .cpu_hold(cpu_hold), .irq(irq));

  dma_ctrl_top #(.NCH(4), .WIDE(1'b0)) i_dma_ctrl_top_n (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rd_ch(reg_rd_ch), .reg_rd_sel(reg_rd_sel),
    .reg_rdata(reg_rdata_n), .ext_hold(ext_hold), .xfer_start(xfer_start_n),
    .xfer_ch(xfer_ch_n), .xfer_src(xfer_src_n), .xfer_dst(xfer_dst_n),
    .xfer_word(xfer_word_n), .xfer_done(xfer_done), .cpu_hold(cpu_hold_n), .irq(irq_n));

  always #(CLK_NS / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, wcyc = 0, n_log = 0;
  logic [1:0]  lg_ch  [64];
  logic [31:0] lg_src [64];
  logic [31:0] lg_dst [64];
  logic        lg_word[64];
  int          lg_cyc [64];
  int          irq_cnt[4];
  bit          finished = 1'b0;

  always @(posedge clk) cyc++;

  // transfer engine model: completes each unit on the next edge
  always @(negedge clk) begin
    if (xfer_done) xfer_done = 1'b0;
    if (xfer_start) begin
      if (n_log < 64) begin
        lg_ch[n_log] = xfer_ch; lg_src[n_log] = xfer_src; lg_dst[n_log] = xfer_dst;
        lg_word[n_log] = xfer_word; lg_cyc[n_log] = cyc;
      end
      n_log++;
      xfer_done = 1'b1;
    end
    for (int i = 0; i < 4; i++) if (irq[i]) irq_cnt[i]++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] ch, logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    wcyc = cyc;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] ch, logic [2:0] sel, output logic [31:0] w, output logic [31:0] n);
    @(negedge clk);
    reg_rd_ch = ch; reg_rd_sel = sel;
    @(negedge clk);
    w = reg_rdata; n = reg_rdata_n;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] w, n;
    @(negedge clk);
    chk("R4 cpu_hold", 32'(cpu_hold), 0);
    chk("R4 irq", 32'(irq), 0);
    chk("R4 xfer_start", 32'(xfer_start), 0);
    for (int c = 0; c < 4; c++) begin
      rd(2'(c), 3'd3, w, n);
      chk("R4 R2 wide reset count", w, 32'h200000);
      chk("R4 R3 narrow reset count", n, (c == 3) ? 32'h10000 : 32'h4000);
      rd(2'(c), 3'd2, w, n);
      chk("R4 reset ctrl", w, 0);
    end
  endtask

  task automatic t_masks;
    logic [31:0] w, n;
    int base;
    base = n_log;
    wr(2'd0, 2'd0, 32'hFFFF_FFFF);
    wr(2'd0, 2'd1, 32'h1234_5679);
    rd(2'd0, 3'd0, w, n);
    chk("R1 source mask", w, 32'h0FFF_FFFE);
    rd(2'd0, 3'd1, w, n);
    chk("R1 R13 destination mask", w, 32'h0234_5678);
    wr(2'd1, 2'd2, 32'hFFFF_0000);
    rd(2'd1, 3'd2, w, n);
    chk("R2 wide ctrl mask", w, 32'hFFE0_0000);
    chk("R3 narrow ctrl mask", n, 32'hF7E0_0000);
    rd(2'd1, 3'd3, w, n);
    chk("R2 wide count field", w, 32'h1F_0000);
    chk("R3 narrow zero count", n, 32'h4000);
    idle(6);
    chk("R6 nonzero timing never starts", n_log - base, 0);
    wr(2'd1, 2'd2, 32'h0);
    wr(2'd3, 2'd2, 32'h0);
    rd(2'd3, 3'd3, w, n);
    chk("R2 wide zero count ch3", w, 32'h200000);
    chk("R3 narrow zero count ch3", n, 32'h10000);
    wr(2'd2, 2'd2, 32'h0001_0005);
    rd(2'd2, 3'd3, w, n);
    chk("R2 wide count width", w, 32'h10005);
    chk("R3 narrow count width", n, 32'h5);
  endtask

  task automatic t_basic;
    logic [31:0] w, n;
    int base;
    base = n_log;
    for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
    wr(2'd1, 2'd0, 32'h100);
    wr(2'd1, 2'd1, 32'h200);
    wr(2'd1, 2'd2, 32'hC000_0003);
    idle(15);
    chk("R6 unit count", n_log - base, 3);
    chk("R6 start delay", lg_cyc[base] - wcyc, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R8 channel", 32'(lg_ch[base + k]), 1);
      chk("R7 src increment", lg_src[base + k], 32'h100 + 2 * k);
      chk("R7 dst increment", lg_dst[base + k], 32'h200 + 2 * k);
      chk("R7 halfword width", 32'(lg_word[base + k]), 0);
    end
    chk("R11 irq one pulse", irq_cnt[1], 1);
    chk("R11 no other irq", irq_cnt[0] + irq_cnt[2] + irq_cnt[3], 0);
    rd(2'd1, 3'd2, w, n);
    chk("R9 enable cleared", w, 32'h4000_0000);
    chk("R12 hold released", 32'(cpu_hold), 0);
    rd(2'd1, 3'd6, w, n);
    chk("R13 working count zero", w, 0);
    wr(2'd1, 2'd0, 32'h500);
    rd(2'd1, 3'd4, w, n);
    chk("R5 working source kept", w, 32'h106);
  endtask

  task automatic t_modes;
    int base;
    base = n_log;
    wr(2'd0, 2'd0, 32'h400);
    wr(2'd0, 2'd1, 32'h800);
    wr(2'd0, 2'd2, 32'h84C0_0002);
    idle(12);
    chk("R7 mode units", n_log - base, 2);
    chk("R7 src decrement 0", lg_src[base], 32'h400);
    chk("R7 src decrement 1", lg_src[base + 1], 32'h3FC);
    chk("R7 dst fixed", lg_dst[base + 1], 32'h800);
    chk("R7 word width", 32'(lg_word[base]), 1);
  endtask

  task automatic t_reload;
    logic [31:0] w, n;
    int base;
    base = n_log;
    irq_cnt[2] = 0;
    wr(2'd2, 2'd0, 32'h10);
    wr(2'd2, 2'd1, 32'h300);
    wr(2'd2, 2'd2, 32'h8060_0002);
    idle(12);
    chk("R10 units", n_log - base, 2);
    chk("R10 second dst", lg_dst[base + 1], 32'h302);
    rd(2'd2, 3'd5, w, n);
    chk("R10 dst reloaded", w, 32'h300);
    chk("R11 irq off no pulse", irq_cnt[2], 0);
  endtask

  task automatic t_priority;
    int base;
    logic [1:0]  ech [5] = '{2'd2, 2'd1, 2'd1, 2'd2, 2'd2};
    logic [31:0] esrc[5] = '{32'h1000, 32'h2000, 32'h2002, 32'h1002, 32'h1004};
    base = n_log;
    wr(2'd2, 2'd0, 32'h1000);
    wr(2'd1, 2'd0, 32'h2000);
    wr(2'd2, 2'd2, 32'h8000_0003);
    wr(2'd1, 2'd2, 32'h8000_0002);
    idle(20);
    chk("R8 units", n_log - base, 5);
    for (int k = 0; k < 5; k++) begin
      chk("R8 preempt order", 32'(lg_ch[base + k]), 32'(ech[k]));
      chk("R8 preempt src", lg_src[base + k], esrc[k]);
    end
  endtask

  task automatic t_hold;
    int base;
    base = n_log;
    @(negedge clk); ext_hold = 1'b1;
    wr(2'd3, 2'd0, 32'h40);
    wr(2'd3, 2'd2, 32'h8000_0001);
    idle(10);
    chk("R12 deferred", n_log - base, 0);
    chk("R12 hold while active", 32'(cpu_hold), 1);
    ext_hold = 1'b0;
    idle(8);
    chk("R12 runs after release", n_log - base, 1);
    chk("R12 hold dropped", 32'(cpu_hold), 0);
  endtask

  task automatic t_reenable;
    logic [31:0] w, n;
    int base;
    base = n_log;
    wr(2'd0, 2'd2, 32'h8800_0001);
    wr(2'd0, 2'd2, 32'h8000_0001);
    idle(10);
    chk("R5 enable while enabled", n_log - base, 0);
    rd(2'd0, 3'd2, w, n);
    chk("R5 still enabled", w, 32'h8000_0000);
    wr(2'd0, 2'd2, 32'h0);
    wr(2'd0, 2'd2, 32'h8000_0001);
    idle(10);
    chk("R5 fresh enable runs", n_log - base, 1);
  endtask

  task automatic t_repeat;
    logic [31:0] w, n;
    wr(2'd1, 2'd2, 32'h8200_0001);
    idle(10);
    rd(2'd1, 3'd2, w, n);
    chk("R9 repeat with start-now clears", w, 32'h0200_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masks();
    t_basic();
    t_modes();
    t_reload();
    t_priority();
    t_hold();
    t_reenable();
    t_repeat();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule